// File: doc/BRIEF.md
# DDR Burst Column Address Generator

This block produces the internal column addresses for a single read or write burst on a four-bank, 16-bit double-data-rate memory. When a column command is accepted, it captures three things: the start column, the target bank and the auto-precharge flag. It also latches the current burst-length code and ordering bit from the mode register. From the next clock onward it presents two column addresses per clock: one for the rising-edge beat and one for the falling-edge beat.

It flags the clock that carries the final pair of beats. When the command asked for auto-precharge, it pulses a precharge request for the captured bank once that pair is done. A stop command ends a burst early. A low clock enable freezes the whole burst in place. Full-page bursts walk the whole row and repeat until they are stopped.

Top module: `ddr_burst_colgen`

## Requirements
- R1: After reset, `busy`, `last` and `pre_req` are 0, and both beat outputs are 0.
- R2: The burst length comes from `mr_len`, latched with the command: 3'b001 gives 2 beats, 3'b010 gives 4, 3'b011 gives 8 and 3'b111 gives full page. Every other code gives 2 beats.
- R3: With `mr_ilv`=0, beat n keeps the start column's upper bits. Its low log2(BL) bits are the start column's low bits plus n, wrapped within the aligned block of BL columns.
- R4: With `mr_ilv`=1 and a length of 2, 4 or 8, beat n keeps the upper bits. Its low log2(BL) bits are the start column's low bits XOR n.
- R5: A command sampled on clock edge k is followed by pair j in the clock after edge k+j. The pair shows beat 2j on `beat_even` and beat 2j+1 on `beat_odd`.
- R6: `last` is high only in the clock that shows the final pair. At the following edge the burst ends, unless that edge carries a new command.
- R7: In full page, the start column's bit 0 is forced to 0 and the order is sequential whatever `mr_ilv` says. The addresses wrap through all 256 columns and `last` never rises.
- R8: An edge with `cke` low ignores `cmd_go` and `cmd_stop` and changes no burst state, so `busy` and both beats hold.
- R9: When the command had `cmd_ap`=1, `pre_req` is high for exactly the clock after the final pair, with `pre_bank` equal to the captured bank.
- R10: `cmd_stop` during a burst ends it at that edge. `busy` falls, and no precharge request follows.
- R11: `cmd_go` during a burst restarts with the new column, bank, flag and mode. A restart overrides a stop on the same edge.
- R12: While `busy` is 0, both beat outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cke | input | 1 | Clock enable; low freezes the burst |
| mr_len | input | 3 | Burst-length code from the mode register |
| mr_ilv | input | 1 | Ordering: 0 sequential, 1 interleave |
| cmd_go | input | 1 | Read or write command accepted |
| cmd_col | input | 8 | Start column |
| cmd_bank | input | 2 | Target bank |
| cmd_ap | input | 1 | Auto-precharge requested |
| cmd_stop | input | 1 | Burst-stop command |
| busy | output | 1 | Burst in progress |
| last | output | 1 | Final pair of beats this clock |
| beat_even | output | 8 | Column for the rising-edge beat |
| beat_odd | output | 8 | Column for the falling-edge beat |
| pre_req | output | 1 | Precharge request pulse |
| pre_bank | output | 2 | Bank to precharge |

## Verification
The bench uses start columns that are not aligned to the burst. A design that carried out of the aligned block would show columns from the next block. A design that swapped sequential for XOR ordering would give 11,12,13,10 where 11,10,13,12 is due.

A full-page run goes past column 255. A design that stopped, raised `last` or skipped the even-start rule would show a wrong pair.

Three further cases are driven:
- Commands and stops arrive under a low clock enable. A design that honoured them would restart or end the burst.
- A stop lands on a burst with auto-precharge. A design that still raised the request would precharge a bank that should stay open.
- A restart and a stop arrive together. A design that let the stop win would go idle instead of restarting.

// File: rtl/ddr_burst_colgen.sv
module ddr_burst_colgen #(
  parameter int COL_W  = 8,
  parameter int BANK_W = 2,
  parameter int LEN_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cke,
  input  logic [LEN_W-1:0]  mr_len,
  input  logic              mr_ilv,
  input  logic              cmd_go,
  input  logic [COL_W-1:0]  cmd_col,
  input  logic [BANK_W-1:0] cmd_bank,
  input  logic              cmd_ap,
  input  logic              cmd_stop,
  output logic              busy,
  output logic              last,
  output logic [COL_W-1:0]  beat_even,
  output logic [COL_W-1:0]  beat_odd,
  output logic              pre_req,
  output logic [BANK_W-1:0] pre_bank
);

  localparam logic [LEN_W-1:0] LEN_4  = LEN_W'(2);
  localparam logic [LEN_W-1:0] LEN_8  = LEN_W'(3);
  localparam logic [LEN_W-1:0] LEN_FP = LEN_W'(7);
  localparam logic [COL_W-1:0] ONE    = COL_W'(1);
  localparam logic [COL_W-1:0] TWO    = COL_W'(2);

  logic              act_q, fp_q, ilv_q, ap_q;
  logic [BANK_W-1:0] bank_q;
  logic [COL_W-1:0]  base_q, mask_q, idx_q;

  logic              fp_n;
  logic [COL_W-1:0]  mask_n;

  always_comb begin
    fp_n = (mr_len == LEN_FP);
    case (mr_len)
      LEN_4:   mask_n = COL_W'(3);
      LEN_8:   mask_n = COL_W'(7);
      LEN_FP:  mask_n = '1;
      default: mask_n = COL_W'(1);
    endcase
  end

  function automatic logic [COL_W-1:0] col_at(input logic [COL_W-1:0] off);
    logic [COL_W-1:0] low;
    low = ilv_q ? (base_q ^ off) : (base_q + off);
    return (base_q & ~mask_q) | (low & mask_q);
  endfunction

  assign busy      = act_q;
  assign last      = act_q && !fp_q && (idx_q == (mask_q & ~ONE));
  assign beat_even = act_q ? col_at(idx_q) : '0;
  assign beat_odd  = act_q ? col_at(idx_q + ONE) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q    <= 1'b0;
      fp_q     <= 1'b0;
      ilv_q    <= 1'b0;
      ap_q     <= 1'b0;
      bank_q   <= '0;
      base_q   <= '0;
      mask_q   <= '0;
      idx_q    <= '0;
      pre_req  <= 1'b0;
      pre_bank <= '0;
    end else begin
      pre_req <= 1'b0;
      if (cke) begin
        if (last && ap_q && !(cmd_stop && !cmd_go)) begin
          pre_req  <= 1'b1;
          pre_bank <= bank_q;
        end
        if (cmd_go) begin
          act_q  <= 1'b1;
          fp_q   <= fp_n;
          ilv_q  <= mr_ilv && !fp_n;
          ap_q   <= cmd_ap;
          bank_q <= cmd_bank;
          mask_q <= mask_n;
          base_q <= fp_n ? (cmd_col & ~ONE) : cmd_col;
          idx_q  <= '0;
        end else if (act_q && (cmd_stop || last)) begin
          act_q <= 1'b0;
        end else if (act_q) begin
          idx_q <= idx_q + TWO;
        end
      end
    end
  end

endmodule

// File: rtl/ddr_burst_colgen_chk.sv
module ddr_burst_colgen_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cke,
  input logic       cmd_go,
  input logic       cmd_stop,
  input logic       busy,
  input logic       last,
  input logic [7:0] beat_even,
  input logic [7:0] beat_odd,
  input logic       pre_req
);

  p_idle_zero_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (beat_even == 8'h00 && beat_odd == 8'h00));

  p_pair_r5: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (beat_even[0] != beat_odd[0]));

  p_freeze_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !cke) |=> (busy && $stable(beat_even) && $stable(beat_odd)));

  p_stop_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cke && cmd_stop && !cmd_go) |=> (!busy && !pre_req));

  p_last_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    last |-> busy);

  p_last_end_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (last && cke && !cmd_go) |=> !busy);

  p_pre_after_last_r9: assert property (@(posedge clk) disable iff (!rst_n)
    pre_req |-> $past(last && cke));

endmodule

bind ddr_burst_colgen ddr_burst_colgen_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cke(cke), .cmd_go(cmd_go), .cmd_stop(cmd_stop),
  .busy(busy), .last(last), .beat_even(beat_even), .beat_odd(beat_odd),
  .pre_req(pre_req)
);

// File: tb/ddr_burst_colgen_tb.sv
`timescale 1ns/1ps
module ddr_burst_colgen_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cke = 1'b1;
  logic [2:0] mr_len = 3'b001;
  logic       mr_ilv = 1'b0;
  logic       cmd_go = 1'b0;
  logic [7:0] cmd_col = 8'h00;
  logic [1:0] cmd_bank = 2'd0;
  logic       cmd_ap = 1'b0;
  logic       cmd_stop = 1'b0;
  logic       busy, last, pre_req;
  logic [7:0] beat_even, beat_odd;
  logic [1:0] pre_bank;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  ddr_burst_colgen u_dut (
    .clk(clk), .rst_n(rst_n), .cke(cke), .mr_len(mr_len), .mr_ilv(mr_ilv),
    .cmd_go(cmd_go), .cmd_col(cmd_col), .cmd_bank(cmd_bank), .cmd_ap(cmd_ap),
    .cmd_stop(cmd_stop), .busy(busy), .last(last), .beat_even(beat_even),
    .beat_odd(beat_odd), .pre_req(pre_req), .pre_bank(pre_bank)
  );

  typedef struct packed {
    logic [2:0]       len;
    logic             ilv;
    logic [7:0]       col;
    logic             ap;
    logic [1:0]       bank;
    logic [3:0]       n;
    logic [0:7][7:0]  e;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VT [NV] = '{
    '{3'b001, 1'b0, 8'h35, 1'b1, 2'd1, 4'd2, {8'h35, 8'h34, 48'h0}},
    '{3'b010, 1'b0, 8'h11, 1'b0, 2'd2, 4'd4, {8'h11, 8'h12, 8'h13, 8'h10, 32'h0}},
    '{3'b010, 1'b1, 8'h11, 1'b1, 2'd3, 4'd4, {8'h11, 8'h10, 8'h13, 8'h12, 32'h0}},
    '{3'b011, 1'b0, 8'h45, 1'b1, 2'd0, 4'd8, {8'h45, 8'h46, 8'h47, 8'h40, 8'h41, 8'h42, 8'h43, 8'h44}},
    '{3'b011, 1'b1, 8'h45, 1'b0, 2'd1, 4'd8, {8'h45, 8'h44, 8'h47, 8'h46, 8'h41, 8'h40, 8'h43, 8'h42}},
    '{3'b000, 1'b0, 8'hA2, 1'b1, 2'd2, 4'd2, {8'hA2, 8'hA3, 48'h0}},
    '{3'b101, 1'b1, 8'hFF, 1'b0, 2'd3, 4'd2, {8'hFF, 8'hFE, 48'h0}},
    '{3'b011, 1'b0, 8'hF8, 1'b1, 2'd2, 4'd8, {8'hF8, 8'hF9, 8'hFA, 8'hFB, 8'hFC, 8'hFD, 8'hFE, 8'hFF}}
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic pair(input string req, input logic [7:0] ev, input logic [7:0] od,
                      input logic lst);
    chk(req, {busy, last, beat_even, beat_odd}, {1'b1, lst, ev, od});
  endtask

  task automatic issue(input logic [2:0] len, input logic ilv, input logic [7:0] col,
                       input logic ap, input logic [1:0] bank);
    mr_len = len; mr_ilv = ilv; cmd_col = col; cmd_ap = ap; cmd_bank = bank;
    cmd_go = 1'b1;
    @(negedge clk);
    cmd_go = 1'b0;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=<20000", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 / R12: reset state
    chk("R1", {busy, last, pre_req, beat_even, beat_odd}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R12", {beat_even, beat_odd}, 0);

    // R2 R3 R4 R5 R6 R9: table of bursts
    for (int v = 0; v < NV; v++) begin
      issue(VT[v].len, VT[v].ilv, VT[v].col, VT[v].ap, VT[v].bank);
      for (int j = 0; j < VT[v].n / 2; j++) begin
        pair($sformatf("R3/R4/R5 vec%0d pair%0d", v, j), VT[v].e[2*j], VT[v].e[2*j+1],
             (j == VT[v].n / 2 - 1));
        @(negedge clk);
      end
      chk($sformatf("R6/R9 vec%0d end", v), {busy, pre_req, pre_bank},
          {1'b0, VT[v].ap, VT[v].ap ? VT[v].bank : pre_bank});
      @(negedge clk);
    end

    // R7: full page, odd start forced even, interleave ignored, wraps past 255
    issue(3'b111, 1'b1, 8'h03, 1'b1, 2'd1);
    for (int k = 0; k < 130; k++) begin
      pair($sformatf("R7 fp pair%0d", k), 8'(2 + 2*k), 8'(3 + 2*k), 1'b0);
      @(negedge clk);
    end
    // R10: stop ends the burst, no precharge even with ap set
    cmd_stop = 1'b1;
    @(negedge clk);
    cmd_stop = 1'b0;
    chk("R10 stop", {busy, pre_req}, 0);
    @(negedge clk);
    chk("R10 no late pre", {busy, pre_req}, 0);

    // R8: freeze under low cke, commands ignored
    issue(3'b011, 1'b0, 8'h40, 1'b1, 2'd3);
    pair("R8 pre-freeze", 8'h40, 8'h41, 1'b0);
    cke = 1'b0; cmd_stop = 1'b1;
    @(negedge clk);
    pair("R8 stop ignored", 8'h40, 8'h41, 1'b0);
    cmd_stop = 1'b0; cmd_go = 1'b1; cmd_col = 8'h00; cmd_ap = 1'b0;
    @(negedge clk);
    pair("R8 go ignored", 8'h40, 8'h41, 1'b0);
    cmd_go = 1'b0; cke = 1'b1;
    @(negedge clk);
    pair("R8 resume", 8'h42, 8'h43, 1'b0);
    @(negedge clk);
    pair("R8 p2", 8'h44, 8'h45, 1'b0);
    @(negedge clk);
    pair("R8 p3", 8'h46, 8'h47, 1'b1);
    @(negedge clk);
    chk("R9 after freeze", {busy, pre_req, pre_bank}, {1'b0, 1'b1, 2'd3});
    @(negedge clk);
    chk("R9 single pulse", {1'b0, pre_req}, 0);

    // R10: stop on final pair with ap set gives no request
    issue(3'b010, 1'b0, 8'h20, 1'b1, 2'd2);
    pair("R10 bl4 p0", 8'h20, 8'h21, 1'b0);
    @(negedge clk);
    pair("R10 bl4 p1", 8'h22, 8'h23, 1'b1);
    cmd_stop = 1'b1;
    @(negedge clk);
    cmd_stop = 1'b0;
    chk("R10 stop at last", {busy, pre_req}, 0);

    // R11: restart with stop on the same edge; restart wins
    issue(3'b011, 1'b0, 8'h10, 1'b0, 2'd0);
    pair("R11 first", 8'h10, 8'h11, 1'b0);
    mr_len = 3'b010; mr_ilv = 1'b1; cmd_col = 8'h21; cmd_ap = 1'b1; cmd_bank = 2'd1;
    cmd_go = 1'b1; cmd_stop = 1'b1;
    @(negedge clk);
    cmd_go = 1'b0; cmd_stop = 1'b0;
    pair("R11 restart p0", 8'h21, 8'h20, 1'b0);
    @(negedge clk);
    pair("R11 restart p1", 8'h23, 8'h22, 1'b1);
    @(negedge clk);
    chk("R11 restart end", {busy, pre_req, pre_bank}, {1'b0, 1'b1, 2'd1});

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule